// File: doc/BRIEF.md
# In-System Flash Programming Sequencer

This block is the target-side controller for an in-system programming session on an on-chip configuration flash array. A test access port, which is outside this block, delivers decoded commands together with an address and a data word. It also delivers a level that is high while the port sits in Run-Test/Idle. The sequencer tracks the session mode and checks the device identity before it allows any array access. It times erase and program pulses purely by counting clock cycles spent in Run-Test/Idle. No explicit "go" command exists.

A register-array model inside the block stands in for the flash cells. The array has a configuration region below a parameterised base address and a user region at and above it. Two flag bits are kept beside the array:

- The done bit is written last in a session. Until it is set, no I/O pin may drive.
- The security bit hides the configuration region from read-back. Only a bulk erase clears it.

A full session issues these commands in order: enter, identity check, erase, program (once per address), verify (once per address), exit. A verify-only session skips erase and program.

Top module: `isp_flash_seq`

## Requirements
- R1: After synchronous active-low reset, these outputs are all 0: `isp_mode`, `id_ok`, `busy`, `pulse_err`, `rd_valid`, `io_oe`. `io_pullup` is 1, every array word reads all ones, and both flags are clear.
- R2: Command codes on `cmd_code` are 0 none, 1 enter, 2 identity check, 3 bulk erase, 4 program, 5 verify, 6 exit, 7 flag program.
  - Outside ISP mode every command except enter is ignored.
  - Enter sets `isp_mode` at the accepting edge.
  - Exit clears both `isp_mode` and `id_ok`.
- R3: The identity check sets `id_ok` when `cmd_data` equals the parameter `DEV_ID`, and clears it otherwise. Erase, program, verify and flag program are ignored while `id_ok` is 0.
- R4: Bulk erase becomes pending when accepted. It completes on the `ERASE_CYC`-th clock spent with `rti` high. On completion every word becomes all ones, the done and security bits clear, and `arr_erase_stb` is high for the following cycle.
- R5: Program becomes pending when accepted. It completes on the `PROG_CYC`-th clock spent with `rti` high. The addressed word then becomes its old value ANDed with `cmd_data`, and `arr_wr_stb` is high for the following cycle.
- R6: If `rti` goes low after at least one counted cycle but before the count completes, the pulse is aborted and the array and flags are unchanged. `pulse_err` is then 1 until the next accepted command.
- R7: The cycle after an accepted verify command, `rd_valid` is 1 for one cycle and `rd_data` holds the addressed word.
- R8: While the security bit is set, a verify of an address below `UFM_BASE` returns zero. Addresses at or above `UFM_BASE` still return their content.
- R9: Flag program uses the program pulse length. On completion, `cmd_data` bit 0 sets the done bit and bit 1 sets the security bit. Neither bit is ever cleared except by bulk erase.
- R10: `io_oe` is 1 only when the done bit is set and ISP mode is off. `io_pullup` is always the inverse of `io_oe`.
- R11: While a pulse is pending (`busy` is 1), every command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 3 | Decoded command code |
| cmd_addr | input | AW | Array word address |
| cmd_data | input | DW | Program data, identity, or flag bits |
| rti | input | 1 | High while the port is in Run-Test/Idle |
| isp_mode | output | 1 | ISP session active |
| id_ok | output | 1 | Identity check passed |
| busy | output | 1 | Erase or program pulse pending |
| pulse_err | output | 1 | Last pulse aborted |
| arr_erase_stb | output | 1 | One-cycle strobe after bulk erase |
| arr_wr_stb | output | 1 | One-cycle strobe after program or flag write |
| rd_valid | output | 1 | Verify data valid |
| rd_data | output | DW | Verify data |
| io_oe | output | 1 | User I/O pins may drive |
| io_pullup | output | 1 | User I/O pins tri-stated with weak pull-up |

## Verification
The assertions take for granted that `rti` only rises after a pulse command has been accepted, or while no pulse is pending. They also assume verify and program never touch the array in the same cycle. The busy gate makes that second assumption true.

The stimulus holds `rti` low while it presents commands, then raises it for either the full count or a deliberately short count. It keeps every random address inside the array and uses random data of full width. It issues pulse commands only after a passing identity check, except in the directed cases that probe the ignore rules.

// File: rtl/isp_seq_pkg.sv
// Package: shared command and operation encodings for the ISP sequencer.
// Assumes: the command code is 3 bits wide and decoded by the TAP.
package isp_seq_pkg;
    typedef enum logic [2:0] {
        C_NOP   = 3'd0,
        C_ENTER = 3'd1,
        C_IDCHK = 3'd2,
        C_ERASE = 3'd3,
        C_PROG  = 3'd4,
        C_READ  = 3'd5,
        C_EXIT  = 3'd6,
        C_FLAGS = 3'd7
    } isp_cmd_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2,
        OP_FLAGS = 2'd3
    } isp_op_e;
endpackage

// File: rtl/isp_pulse_timer.sv
// Module: counts clocks spent in Run-Test/Idle for a pending pulse.
// Signals completion (fire) on the final counted clock.
// Signals abort when rti drops after counting has begun.
// Assumes: start is only asserted while not busy; both limits are >= 1.
module isp_pulse_timer #(
    parameter int ERASE_CYC = 3500000,
    parameter int PROG_CYC  = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_long,
    input  logic rti,
    output logic busy,
    output logic fire,
    output logic abort
);
    localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LIM_L = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] LIM_S = CW'(PROG_CYC - 1);

    logic [CW-1:0] cnt;
    logic          long_q;
    logic [CW-1:0] lim;

    // Select the terminal count for the pending pulse
    always_comb lim = long_q ? LIM_L : LIM_S;

    // Completion and abort conditions for the pending pulse
    always_comb begin
        fire  = busy && rti && (cnt == lim);
        abort = busy && !rti && (cnt != '0);
    end

    // Pending flag and Run-Test/Idle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            long_q <= 1'b0;
        end else if (start) begin
            busy   <= 1'b1;
            cnt    <= '0;
            long_q <= start_long;
        end else if (fire || abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy && rti) begin
            cnt <= cnt + 1'b1;
        end
    end

    // An abort only follows a cycle that was counted in Run-Test/Idle
    p_abort_after_rti_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $past(rti));
endmodule

// File: rtl/isp_cell_array.sv
// Module: register model of the flash cells plus the done and security flags.
// Erase sets all words to ones. Program ANDs data in.
// Reads of the configuration region are masked while secured.
// Assumes: erase, wr, flag_wr and rd are mutually exclusive in a cycle.
module isp_cell_array #(
    parameter int AW       = 4,
    parameter int DW       = 16,
    parameter int UFM_BASE = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase,
    input  logic          wr,
    input  logic          flag_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    flag_data,
    input  logic          rd,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          done_bit,
    output logic          secure_bit
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] UBASE = AW'(UFM_BASE);

    logic [DW-1:0] mem [DEPTH];

    // Cell contents: erase to ones, program by clearing bits only
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr) begin
            mem[addr] <= mem[addr] & wdata;
        end
    end

    // Done and security flags: set by flag program, cleared by erase
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            done_bit   <= 1'b0;
            secure_bit <= 1'b0;
        end else if (flag_wr) begin
            done_bit   <= done_bit | flag_data[0];
            secure_bit <= secure_bit | flag_data[1];
        end
    end

    // Verify read port with security masking of the configuration region
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd;
            if (rd) rd_data <= (secure_bit && (rd_addr < UBASE)) ? '0 : mem[rd_addr];
        end
    end

    // A program never sets a bit that was clear
    p_prog_clears_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((mem[$past(addr)] | $past(mem[addr])) == $past(mem[addr])));
    // Secured configuration reads return zero
    p_secure_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && secure_bit && (rd_addr < UBASE)) |=> (rd_data == '0));
    // Flags only fall through an erase
    p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(done_bit) || $fell(secure_bit)) |-> $past(erase));
endmodule

// File: rtl/isp_seq_ctrl.sv
// Module: session mode tracking, command acceptance, operand latching, error flag.
// Assumes: commands arrive decoded, one per cycle, with cmd_valid.
module isp_seq_ctrl
    import isp_seq_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter logic [DW-1:0] DEV_ID = 16'hA4DD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_code,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          busy,
    input  logic          fire,
    input  logic          abort,
    output logic          isp_mode,
    output logic          id_ok,
    output logic          pulse_err,
    output logic          start,
    output logic          start_long,
    output logic          rd,
    output logic          erase_go,
    output logic          wr_go,
    output logic          flag_go,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data
);
    isp_cmd_e code;
    isp_op_e  op_q;
    logic     legal, accept;

    // Decide whether the presented command is legal in the current mode
    always_comb begin
        code = isp_cmd_e'(cmd_code);
        unique case (code)
            C_ENTER:                          legal = 1'b1;
            C_IDCHK, C_EXIT:                  legal = isp_mode;
            C_ERASE, C_PROG, C_READ, C_FLAGS: legal = isp_mode && id_ok;
            default:                          legal = 1'b0;
        endcase
        accept     = cmd_valid && !busy && legal;
        start      = accept && (code == C_ERASE || code == C_PROG || code == C_FLAGS);
        start_long = (code == C_ERASE);
        rd         = accept && (code == C_READ);
    end

    // Route pulse completion to the matching array action
    always_comb begin
        erase_go = fire && (op_q == OP_ERASE);
        wr_go    = fire && (op_q == OP_PROG);
        flag_go  = fire && (op_q == OP_FLAGS);
    end

    // Session mode and identity state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isp_mode <= 1'b0;
            id_ok    <= 1'b0;
        end else if (accept) begin
            case (code)
                C_ENTER: isp_mode <= 1'b1;
                C_IDCHK: id_ok    <= (cmd_data == DEV_ID);
                C_EXIT:  begin isp_mode <= 1'b0; id_ok <= 1'b0; end
                default: ;
            endcase
        end
    end

    // Latch operation kind and operands for a pending pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            op_addr <= '0;
            op_data <= '0;
        end else if (start) begin
            op_q    <= (code == C_ERASE) ? OP_ERASE : (code == C_PROG) ? OP_PROG : OP_FLAGS;
            op_addr <= cmd_addr;
            op_data <= cmd_data;
        end
    end

    // Sticky abort flag, cleared by the next accepted command
    always_ff @(posedge clk) begin
        if (!rst_n)      pulse_err <= 1'b0;
        else if (abort)  pulse_err <= 1'b1;
        else if (accept) pulse_err <= 1'b0;
    end

    // No array access is legal before the identity check passes
    p_id_before_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start || rd) |-> id_ok);
    // Nothing is accepted while a pulse is pending
    p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(isp_mode) && $stable(id_ok));
endmodule

// File: rtl/isp_flash_seq.sv
// Module: top of the in-system flash programming sequencer.
// Joins the controller, the Run-Test/Idle pulse timer and the cell model.
// Produces the completion strobes and the I/O pin control.
// Assumes: rti is synchronous to clk; commands are single-cycle.
module isp_flash_seq
    import isp_seq_pkg::*;
#(
    parameter int AW        = 4,
    parameter int DW        = 16,
    parameter int UFM_BASE  = 12,
    parameter int ERASE_CYC = 3500000,
    parameter int PROG_CYC  = 750,
    parameter logic [DW-1:0] DEV_ID = 16'hA4DD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_code,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          rti,
    output logic          isp_mode,
    output logic          id_ok,
    output logic          busy,
    output logic          pulse_err,
    output logic          arr_erase_stb,
    output logic          arr_wr_stb,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          io_oe,
    output logic          io_pullup
);
    logic          start, start_long, fire, abort, rd;
    logic          erase_go, wr_go, flag_go;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic          done_bit, secure_bit;

    isp_seq_ctrl #(.AW(AW), .DW(DW), .DEV_ID(DEV_ID)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .fire(fire),
        .abort(abort), .isp_mode(isp_mode), .id_ok(id_ok), .pulse_err(pulse_err),
        .start(start), .start_long(start_long), .rd(rd), .erase_go(erase_go),
        .wr_go(wr_go), .flag_go(flag_go), .op_addr(op_addr), .op_data(op_data)
    );

    isp_pulse_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_long(start_long),
        .rti(rti), .busy(busy), .fire(fire), .abort(abort)
    );

    isp_cell_array #(.AW(AW), .DW(DW), .UFM_BASE(UFM_BASE)) u_cells (
        .clk(clk), .rst_n(rst_n), .erase(erase_go), .wr(wr_go), .flag_wr(flag_go),
        .addr(op_addr), .wdata(op_data), .flag_data(op_data[1:0]), .rd(rd),
        .rd_addr(cmd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .done_bit(done_bit), .secure_bit(secure_bit)
    );

    // One-cycle completion strobes toward the array interface
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_erase_stb <= 1'b0;
            arr_wr_stb    <= 1'b0;
        end else begin
            arr_erase_stb <= erase_go;
            arr_wr_stb    <= wr_go || flag_go;
        end
    end

    // Pins drive only outside ISP and once the done bit is programmed
    always_comb begin
        io_oe     = done_bit && !isp_mode;
        io_pullup = !io_oe;
    end

    // An erase strobe follows a clock spent in Run-Test/Idle
    p_erase_after_rti_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase_stb |-> $past(rti));
    // A write strobe follows a clock spent in Run-Test/Idle
    p_write_after_rti_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_stb |-> $past(rti));
    // Entering ISP stops the pins driving on the same cycle
    p_quiet_in_isp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isp_mode) |-> !io_oe);
endmodule

// File: tb/test_isp_flash_seq.sv
module test_isp_flash_seq;
    localparam int AW = 4, DW = 16, UB = 12, EC = 20, PC = 5;
    localparam logic [DW-1:0] ID = 16'hA4DD;

    logic clk = 0, rst_n = 0, cmd_valid = 0, rti = 0;
    logic [2:0] cmd_code = 0;
    logic [AW-1:0] cmd_addr = 0;
    logic [DW-1:0] cmd_data = 0;
    logic isp_mode, id_ok, busy, pulse_err, arr_erase_stb, arr_wr_stb;
    logic rd_valid, io_oe, io_pullup;
    logic [DW-1:0] rd_data;

    int total = 0, bad = 0, cyc = 0;
    logic [DW-1:0] model [1 << AW];
    logic m_sec = 0;

    always #2 clk = ~clk;

    isp_flash_seq #(.AW(AW), .DW(DW), .UFM_BASE(UB), .ERASE_CYC(EC),
                    .PROG_CYC(PC), .DEV_ID(ID)) i_isp_flash_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rti(rti), .isp_mode(isp_mode),
        .id_ok(id_ok), .busy(busy), .pulse_err(pulse_err),
        .arr_erase_stb(arr_erase_stb), .arr_wr_stb(arr_wr_stb),
        .rd_valid(rd_valid), .rd_data(rd_data), .io_oe(io_oe), .io_pullup(io_pullup)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        return (m_sec && a < UB) ? '0 : model[a];
    endfunction

    task automatic issue(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cmd_valid = 1; cmd_code = c; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 0; cmd_code = 0;
    endtask

    task automatic run_rti(input int n);
        rti = 1;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
        issue(3'd4, a, d);
        run_rti(PC);
        @(negedge clk);
        check("R5 wr strobe", arr_wr_stb, 1);
        rti = 0;
        model[a] = model[a] & d;
    endtask

    task automatic verify(input logic [AW-1:0] a, input string req);
        issue(3'd5, a, '0);
        check({req, " rd_valid"}, rd_valid, 1);
        check({req, " rd_data"}, rd_data, exp_read(a));
    endtask

    task automatic erase_all();
        issue(3'd3, 0, 0);
        run_rti(EC);
        @(negedge clk);
        check("R4 erase strobe", arr_erase_stb, 1);
        check("R4 busy clear", busy, 0);
        rti = 0;
        for (int i = 0; i < (1 << AW); i++) model[i] = '1;
        m_sec = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < (1 << AW); i++) model[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 isp_mode", isp_mode, 0);
        check("R1 busy", busy, 0);
        check("R1 io_oe", io_oe, 0);
        check("R1 io_pullup", io_pullup, 1);
        check("R1 pulse_err", pulse_err, 0);

        // R2: commands outside ISP ignored
        issue(3'd5, 3, 0);
        check("R2 read ignored outside isp", rd_valid, 0);
        issue(3'd1, 0, 0);
        check("R2 enter", isp_mode, 1);
        check("R10 pullup in isp", io_pullup, 1);

        // R3: identity gate
        issue(3'd5, 3, 0);
        check("R3 read ignored before id", rd_valid, 0);
        issue(3'd2, 0, 16'h1234);
        check("R3 wrong id", id_ok, 0);
        issue(3'd2, 0, ID);
        check("R3 right id", id_ok, 1);
        verify(5, "R1 erased after reset");

        // R4 + R11: erase, with a program attempt while busy
        issue(3'd3, 0, 0);
        check("R11 busy after erase cmd", busy, 1);
        issue(3'd4, 2, 16'h0000);
        run_rti(EC);
        @(negedge clk);
        check("R4 erase strobe", arr_erase_stb, 1);
        rti = 0;
        verify(2, "R11 program ignored while busy");
        verify(15, "R4 erased word");

        // R5: program twice ANDs
        prog(3, 16'h1234);
        verify(3, "R5 first program");
        prog(3, 16'h00F0);
        verify(3, "R5 second program");

        // R6: aborted pulse
        issue(3'd4, 4, 16'h0000);
        run_rti(3);
        @(negedge clk);
        rti = 0;
        @(negedge clk);
        check("R6 pulse_err", pulse_err, 1);
        check("R6 busy clear", busy, 0);
        verify(4, "R6 word unchanged");
        check("R6 err cleared by next cmd", pulse_err, 0);

        // R5/R7: random programs and verifies
        for (int k = 0; k < 40; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, (1 << AW) - 1));
            if ($urandom_range(0, 1) == 1) prog(a, DW'($urandom));
            else verify(a, "R7 random verify");
        end
        for (int i = 0; i < (1 << AW); i++) verify(AW'(i), "R7 sweep");

        // R9 + R10: done bit then exit
        issue(3'd7, 0, 16'h0001);
        run_rti(PC);
        @(negedge clk);
        check("R9 flag strobe", arr_wr_stb, 1);
        rti = 0;
        check("R10 no drive in isp", io_oe, 0);
        issue(3'd6, 0, 0);
        check("R2 exit mode", isp_mode, 0);
        check("R2 exit id", id_ok, 0);
        check("R10 drive after done", io_oe, 1);
        check("R10 pullup off", io_pullup, 0);

        // R8: security masks config region only
        issue(3'd1, 0, 0);
        check("R10 quiet on reenter", io_oe, 0);
        issue(3'd2, 0, ID);
        issue(3'd7, 0, 16'h0002);
        run_rti(PC);
        @(negedge clk);
        rti = 0;
        m_sec = 1;
        prog(3, 16'h0FFF);
        verify(3, "R8 secured config reads zero");
        verify(13, "R8 user region readable");
        verify(UB - 1, "R8 last config word zero");
        verify(UB, "R8 first user word");

        // R9 + R4: only erase clears flags
        issue(3'd7, 0, 16'h0000);
        run_rti(PC);
        @(negedge clk);
        rti = 0;
        verify(3, "R9 secure sticky");
        erase_all();
        verify(3, "R4 secure cleared by erase");
        issue(3'd6, 0, 0);
        check("R9 done cleared by erase", io_oe, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule